// File: doc/BRIEF.md
# Sector Hamming Check-Code Generator

This block computes a 24-bit single-error-correcting check code over one flash sector of 256 bytes. Bytes arrive one per cycle on a valid/ready stream. Each byte adds to two groups of even-parity accumulators. The row group is selected by the byte's position in the sector. The column group is selected by the bit position inside the byte. When the last byte of the sector is accepted, the block packs the parities into three code bytes, inverts them, registers them and raises a one-cycle done pulse. The inversion makes an erased sector, where every byte reads 0xFF, give an all-ones code. That code equals the erased spare area, so a blank page needs no special case.

A start flag sent with a byte marks that byte as sector position 0. Any partial accumulation is dropped at that point. This lets the feeding logic abandon a sector at any time. A sector that follows a completed one needs no start flag, because the position counter wraps to 0 on its own. The code outputs keep their value until the next sector completes. A downstream writer can therefore take them whenever it is ready.

Top module: `hecc_gen256`

## Requirements
- R1: Reset state: the code outputs are all ones, so `code_row` = 0xFFFF and `code_col` = 0xFF. `code_done` is 0. `in_ready` goes high after reset and stays high.
- R2: Bit 2k+1 of the row parity vector (k = 0..7) is the even parity of all bits of the bytes whose sector position has bit k set.
- R3: Bit 2k of the row parity vector is the even parity of the bytes whose position has bit k clear. It always equals the total data parity XOR bit 2k+1.
- R4: Column parity cp(2j) (j = 0..2) is the parity, summed over all bytes, of the data bits whose bit index has bit j clear. cp(2j+1) covers the data bits whose bit index has bit j set. So cp0 covers bits 0,2,4,6; cp1 covers 1,3,5,7; cp2 covers 0,1,4,5; cp3 covers 2,3,6,7; cp4 covers 0–3; cp5 covers 4–7.
- R5: `code_row[7:0]` holds the row parity bits 7..0 in bits 7..0, and `code_row[15:8]` holds the row parity bits 15..8, each after inversion.
- R6: `code_col[7:2]` holds cp5..cp0 after inversion, and `code_col[1:0]` is 2'b11 in every result.
- R7: Every code bit is the inverse of its parity, so a sector of 256 bytes of 0xFF gives code_col = 0xFF and code_row = 0xFFFF.
- R8: A byte accepted with `in_start` high becomes position 0 of a new sector. All earlier partial accumulation is discarded, and no done pulse results from the aborted sector.
- R9: `code_done` is high for exactly one cycle. That cycle immediately follows the clock edge at which the 256th byte of a sector is accepted.
- R10: `code_row` and `code_col` change only in the cycle where `code_done` is high.
- R11: A cycle with `in_valid` low has no effect, whatever `in_data` and `in_start` carry. Such a cycle is not counted as a sector position.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data byte is offered |
| in_ready | output | 1 | Block accepts bytes (high from the first cycle after reset) |
| in_start | input | 1 | With an accepted byte: this byte is sector position 0 |
| in_data | input | 8 | Data byte |
| code_row | output | 2*log2(SECTOR_BYTES) (16) | Inverted row parities: [7:0] code byte 0, [15:8] code byte 1 |
| code_col | output | 8 | Code byte 2: inverted cp5..cp0 in [7:2], ones in [1:0] |
| code_done | output | 1 | One-cycle pulse when a new code is registered |

## Verification
The checker assumes that `in_valid`, `in_start` and `in_data` are always 0 or 1 and never unknown, including in the reset cycles. It treats `in_start` as meaningful only when a byte is accepted. The stimulus drives every input from time zero. It changes inputs only on the falling clock edge. In idle gap cycles it deliberately puts a raised start flag and junk data on the bus, which tests that unaccepted cycles are ignored. Sectors are only aborted with start on an accepted byte, so any done pulse comes from a full run of 256 accepted bytes.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

   localparam int BYTE_W   = 8;
   localparam int BIDX_W   = 3;              // log2 of BYTE_W
   localparam int COL_PARS = 2 * BIDX_W;     // six column parities

   // even parity of one byte
   function automatic logic byte_par(input logic [BYTE_W-1:0] b);
      return ^b;
   endfunction

   // column parity pair j: even member (bit index bit j clear) or odd member
   function automatic logic col_par(input logic [BYTE_W-1:0] folded,
                                    input int j, input logic odd);
      logic p;
      p = 1'b0;
      for (int b = 0; b < BYTE_W; b++) begin
         if (((b >> j) & 1) == int'(odd)) p ^= folded[b];
      end
      return p;
   endfunction

endpackage

// File: rtl/hecc_col_acc.sv
module hecc_col_acc
   import hecc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              restart,
   input  logic              last,
   input  logic [BYTE_W-1:0] data,
   output logic [BYTE_W-1:0] fold_nx
);

   logic [BYTE_W-1:0] fold_q;

   // running XOR of all bytes; column parities are masks of it
   assign fold_nx = (restart ? '0 : fold_q) ^ data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fold_q <= '0;
      end else if (accept) begin
         fold_q <= last ? '0 : fold_nx;
      end
   end

endmodule

// File: rtl/hecc_row_acc.sv
module hecc_row_acc #(
   parameter int IDX_W         = 8,
   parameter bit KEEP_EVEN_ACC = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               restart,
   input  logic               last,
   input  logic [IDX_W-1:0]   idx,
   input  logic               bit_par,
   input  logic               tot_par_nx,
   output logic [2*IDX_W-1:0] rp_nx
);

   for (genvar k = 0; k < IDX_W; k++) begin : g_pair
      logic odd_q, odd_nx, even_nx;

      assign odd_nx = (restart ? 1'b0 : odd_q) ^ (bit_par & idx[k]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            odd_q <= 1'b0;
         end else if (accept) begin
            odd_q <= last ? 1'b0 : odd_nx;
         end
      end

      if (KEEP_EVEN_ACC) begin : g_full
         logic even_q;
         assign even_nx = (restart ? 1'b0 : even_q) ^ (bit_par & ~idx[k]);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               even_q <= 1'b0;
            end else if (accept) begin
               even_q <= last ? 1'b0 : even_nx;
            end
         end
      end else begin : g_derived
         // even partner = total parity XOR odd partner
         assign even_nx = tot_par_nx ^ odd_nx;
      end

      assign rp_nx[2*k+1] = odd_nx;
      assign rp_nx[2*k]   = even_nx;
   end

endmodule

// File: rtl/hecc_pack.sv
module hecc_pack
   import hecc_pkg::*;
#(
   parameter int ROW_W = 16
) (
   input  logic [ROW_W-1:0]  rp,
   input  logic [BYTE_W-1:0] fold,
   output logic [ROW_W-1:0]  row_code,
   output logic [BYTE_W-1:0] col_code
);

   logic [COL_PARS-1:0] cp;

   for (genvar j = 0; j < BIDX_W; j++) begin : g_cp
      assign cp[2*j]   = col_par(fold, j, 1'b0);
      assign cp[2*j+1] = col_par(fold, j, 1'b1);
   end

   assign row_code = ~rp;
   assign col_code = {~cp, 2'b11};

endmodule

// File: rtl/hecc_gen256.sv
module hecc_gen256
   import hecc_pkg::*;
#(
   parameter int SECTOR_BYTES  = 256,
   parameter bit KEEP_EVEN_ACC = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                in_valid,
   output logic                                in_ready,
   input  logic                                in_start,
   input  logic [7:0]                          in_data,
   output logic [2*$clog2(SECTOR_BYTES)-1:0]   code_row,
   output logic [7:0]                          code_col,
   output logic                                code_done
);

   localparam int IDX_W = $clog2(SECTOR_BYTES);
   localparam int ROW_W = 2 * IDX_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

   if (SECTOR_BYTES < 2 || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_size
      $error("hecc_gen256: SECTOR_BYTES must be a power of two of at least 2");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("hecc_gen256: code layout assumes 8-bit data");
   end

   logic              ready_q;
   logic              accept, last;
   logic [IDX_W-1:0]  cnt_q, idx;
   logic [BYTE_W-1:0] fold_nx;
   logic [ROW_W-1:0]  rp_nx;
   logic [ROW_W-1:0]  row_nx;
   logic [BYTE_W-1:0] col_nx;
   logic [ROW_W-1:0]  row_q;
   logic [BYTE_W-1:0] col_q;
   logic              done_q;

   assign accept = in_valid & ready_q;
   assign idx    = in_start ? '0 : cnt_q;
   assign last   = accept && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         ready_q <= 1'b1;
         if (accept) cnt_q <= last ? '0 : idx + 1'b1;
      end
   end

   hecc_col_acc u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .restart (in_start),
      .last    (last),
      .data    (in_data),
      .fold_nx (fold_nx)
   );

   hecc_row_acc #(
      .IDX_W         (IDX_W),
      .KEEP_EVEN_ACC (KEEP_EVEN_ACC)
   ) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .restart    (in_start),
      .last       (last),
      .idx        (idx),
      .bit_par    (byte_par(in_data)),
      .tot_par_nx (byte_par(fold_nx)),
      .rp_nx      (rp_nx)
   );

   hecc_pack #(
      .ROW_W (ROW_W)
   ) u_pack (
      .rp       (rp_nx),
      .fold     (fold_nx),
      .row_code (row_nx),
      .col_code (col_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q  <= '1;
         col_q  <= '1;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (last) begin
            row_q <= row_nx;
            col_q <= col_nx;
         end
      end
   end

   assign in_ready  = ready_q;
   assign code_row  = row_q;
   assign code_col  = col_q;
   assign code_done = done_q;

endmodule

// File: rtl/hecc_gen256_chk.sv
module hecc_gen256_chk #(
   parameter int SECTOR_BYTES = 256
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              in_valid,
   input logic                              in_ready,
   input logic                              in_start,
   input logic [7:0]                        in_data,
   input logic [2*$clog2(SECTOR_BYTES)-1:0] code_row,
   input logic [7:0]                        code_col,
   input logic                              code_done
);

   localparam int IDX_W = $clog2(SECTOR_BYTES);

   logic             c_acc, c_last, c_ff_nx, c_ff_q;
   logic [IDX_W-1:0] c_cnt, c_idx;

   assign c_acc   = in_valid && in_ready;
   assign c_idx   = in_start ? '0 : c_cnt;
   assign c_last  = c_acc && (c_idx == IDX_W'(SECTOR_BYTES - 1));
   assign c_ff_nx = (in_start ? 1'b1 : c_ff_q) && (in_data == 8'hFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_cnt  <= '0;
         c_ff_q <= 1'b1;
      end else if (c_acc) begin
         c_cnt  <= c_last ? '0 : c_idx + 1'b1;
         c_ff_q <= c_last ? 1'b1 : c_ff_nx;
      end
   end

   p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> in_ready);

   p_erased_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_last && c_ff_nx) |=> (code_row == '1 && code_col == 8'hFF));

   p_abort_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (c_acc && in_start) |=> !code_done);

   p_done_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      c_last |=> code_done);

   p_done_only_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      code_done |-> $past(c_last));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      code_done |=> !code_done);

   p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !code_done |-> ($stable(code_row) && $stable(code_col)));

endmodule

bind hecc_gen256 hecc_gen256_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_start  (in_start),
   .in_data   (in_data),
   .code_row  (code_row),
   .code_col  (code_col),
   .code_done (code_done)
);

// File: tb/sim_hecc_gen256.sv
module sim_hecc_gen256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_start = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic [15:0] code_row;
   logic [7:0]  code_col;
   logic        code_done;

   int checks = 0;
   int errors = 0;

   logic [7:0]  sect [256];
   logic [23:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] lcg = 32'h1234_5678;
   logic        mon_on = 1'b0;

   always #2.5 clk = ~clk;

   hecc_gen256 u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_start  (in_start),
      .in_data   (in_data),
      .code_row  (code_row),
      .code_col  (code_col),
      .code_done (code_done)
   );

   function automatic logic [7:0] rnd8();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg[23:16];
   endfunction

   // model from R2..R7: {code_col, code_row}
   function automatic logic [23:0] model();
      logic [15:0] rp;
      logic [5:0]  cp;
      rp = '0;
      cp = '0;
      for (int i = 0; i < 256; i++) begin
         for (int k = 0; k < 8; k++) begin
            if ((i >> k) & 1) rp[2*k+1] ^= ^sect[i];
            else              rp[2*k]   ^= ^sect[i];
         end
         for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < 3; j++) begin
               if ((b >> j) & 1) cp[2*j+1] ^= sect[i][b];
               else              cp[2*j]   ^= sect[i][b];
            end
         end
      end
      return {~cp, 2'b11, ~rp};
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: n bytes from sect, optional start on first, optional idle gaps
   task automatic drive(input int n, input bit first_start, input bit gaps,
                        input logic [23:0] exp, input bit push, input string req);
      if (push) begin
         exp_q.push_back(exp);
         tag_q.push_back(req);
      end
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 7 == 3)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b1;           // R11: ignored without valid
            in_data  = rnd8();
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_start = first_start && (i == 0);
         in_data  = sect[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_start = 1'b0;
      in_data  = 8'h00;
   endtask

   // monitor / scoreboard
   logic [23:0] held = 24'hFF_FFFF;
   logic        prev_done = 1'b0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (code_done) begin
            if (prev_done) check("R9 single pulse", 32'(code_done), 32'd0);
            if (exp_q.size() == 0) begin
               check("R8/R9 unexpected done", 32'd1, 32'd0);
            end else begin
               string t;
               logic [23:0] e;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, 32'({code_col, code_row}), 32'(e));
               check("R6 low bits", 32'(code_col[1:0]), 32'd3);
            end
            held = {code_col, code_row};
         end else begin
            if ({code_col, code_row} !== held)
               check("R10 hold", 32'({code_col, code_row}), 32'(held));
         end
         prev_done = code_done;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic wait_drain(input string req);
      repeat (3) @(negedge clk);
      check(req, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done", 32'(code_done), 32'd0);
      check("R1 row", 32'(code_row), 32'hFFFF);
      check("R1 col", 32'(code_col), 32'hFF);
      check("R1 ready", 32'(in_ready), 32'd1);
      mon_on = 1'b1;

      // R7: erased sector
      for (int i = 0; i < 256; i++) sect[i] = 8'hFF;
      drive(256, 1'b1, 1'b0, 24'hFF_FFFF, 1'b1, "R7 erased");
      wait_drain("R9 erased done");

      // R2/R5/R6: single bit 0 at position 255
      for (int i = 0; i < 256; i++) sect[i] = 8'h00;
      sect[255] = 8'h01;
      drive(256, 1'b1, 1'b0, 24'hAB_5555, 1'b1, "R2 R4 R5 R6 pos255 bit0");
      wait_drain("R9 pos255 done");

      // R3/R4: bit 7 at position 0
      for (int i = 0; i < 256; i++) sect[i] = 8'h00;
      sect[0] = 8'h80;
      drive(256, 1'b1, 1'b0, 24'h57_AAAA, 1'b1, "R3 R4 R5 R6 pos0 bit7");
      wait_drain("R9 pos0 done");

      // back-to-back random sectors, second without start (counter wrap)
      for (int i = 0; i < 256; i++) sect[i] = rnd8();
      drive(256, 1'b1, 1'b0, model(), 1'b1, "R2 R3 R4 random A");
      for (int i = 0; i < 256; i++) sect[i] = rnd8();
      drive(256, 1'b0, 1'b0, model(), 1'b1, "R2 R3 R4 random B no start");
      wait_drain("R9 random done");

      // R11: idle gaps with start and junk on the bus
      for (int i = 0; i < 256; i++) sect[i] = rnd8();
      drive(256, 1'b1, 1'b1, model(), 1'b1, "R11 gaps ignored");
      wait_drain("R11 gap done");

      // R8: abort after 100 bytes, then restart with start
      for (int i = 0; i < 256; i++) sect[i] = rnd8();
      drive(100, 1'b1, 1'b0, 24'h0, 1'b0, "");
      repeat (4) @(negedge clk);
      check("R8 no done after abort", 32'(exp_q.size()), 32'd0);
      for (int i = 0; i < 256; i++) sect[i] = rnd8();
      drive(256, 1'b1, 1'b0, model(), 1'b1, "R8 restart");
      wait_drain("R8 restart done");

      // R8: abort right before the end (255 bytes) then a full sector
      for (int i = 0; i < 256; i++) sect[i] = 8'h5A;
      drive(255, 1'b1, 1'b0, 24'h0, 1'b0, "");
      for (int i = 0; i < 256; i++) sect[i] = rnd8();
      drive(256, 1'b1, 1'b1, model(), 1'b1, "R8 late abort");
      wait_drain("R8 late abort done");

      // all-zero sector also gives all ones (R7 inversion)
      for (int i = 0; i < 256; i++) sect[i] = 8'h00;
      drive(256, 1'b1, 1'b0, 24'hFF_FFFF, 1'b1, "R7 zero sector");
      wait_drain("R9 zero done");

      // R10: outputs hold during a long idle stretch
      repeat (20) @(negedge clk);
      check("R10 held after idle", 32'({code_col, code_row}), 32'hFF_FFFF);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule